// File: doc/BRIEF.md
# Strip Sample Transposing Buffer

The block sits between several front-end readout chips and a peak-timing stage. Each chip delivers its channels one time sample after another, so data arrive time-major: all channels for sample 0, then all channels for sample 1, and so on. The timing stage needs the opposite order, with every time sample of one strip presented together. The block writes the incoming words into a grid of small dual-port memories and reads them back strip by strip.

There is one memory bank for each pair of chip and sample. Every chip writes into its own group of banks in parallel, and the sample index selects the bank within that group. On the read side the strip counter sweeps every strip position. Its upper bits pick the chip group, and its lower bits address the channel inside each bank. Two event buffers live in each bank, so one event can be read out while the next one is written. An optional filter drops strips that carry no hit flag in any sample.

Top module: `strip_xpose_buf`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `out_valid`, `out_last` and `in_busy` are all 0.
- R2: An accepted word from chip c, with channel k and sample s, becomes sample s of strip c*CHANNELS+k. The upper strip bits, which give the chip index, select the bank group, and the lower strip bits give the channel.
- R3: Within an event, records come out at most one per cycle and in strictly ascending strip order. Sample j of a record sits at `out_samples[j]`. Each word is laid out as bit 8 = hit flag and bits 7:0 = amplitude.
- R4: An event is complete once every chip has delivered its word for channel CHANNELS-1 of sample SAMPLES-1. No record of that event appears before it is complete.
- R5: When `cfg_skip_empty` is 0, every strip from 0 to NUM_CHIPS*CHANNELS-1 is output once.
- R6: When `cfg_skip_empty` is 1, a strip whose hit flags are all 0 is not output. The final strip is the exception: it is always output.
- R7: `out_last` is high only together with the record of the final strip, and that record ends each event.
- R8: A new event can be written while the previous event is read out. Events come out in the order in which they were completed.
- R9: `in_busy` is high while both buffers hold events that have not been read. Any write offered while `in_busy` is high is ignored, and this includes a completion word.
- R10: `in_busy` falls once the last strip of the older event has been read, which is within NUM_CHIPS*CHANNELS+4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_skip_empty | input | 1 | 1 = suppress strips without any hit flag |
| in_valid | input | NUM_CHIPS | Per-chip word strobe |
| in_chan | input | NUM_CHIPS x log2(CHANNELS) | Per-chip channel index |
| in_smp | input | NUM_CHIPS x log2(SAMPLES) | Per-chip time-sample index |
| in_data | input | NUM_CHIPS x 9 | Per-chip word {hit, amplitude} |
| in_busy | output | 1 | Both buffers occupied; writes dropped |
| out_valid | output | 1 | Output record valid |
| out_strip | output | log2(NUM_CHIPS*CHANNELS) | Strip position of the record |
| out_samples | output | SAMPLES x 9 | All samples of the strip |
| out_last | output | 1 | Record is the final strip of the event |

## Verification
The bench runs a reduced geometry of four chips, 16 channels and 3 samples. This makes reads slower than writes, so the state where both buffers are full can actually be reached. Every strip of every event is compared against amplitudes and hit flags computed in the bench. A swapped chip and bank mapping, or a swapped sample and bank mapping, would therefore show up as wrong words at predictable strips. Events are written back to back to stress the buffer swap: an early release or a missed toggle would either repeat an event or corrupt it. While `in_busy` is high the bench offers garbage completion words that target the buffer still being read. A design that accepted them would corrupt that readout or emit an extra event. The skip mode is checked against the hit pattern in the bench, including the final strip, which must appear even when it is empty.

// File: rtl/strip_xpose_pkg.sv
package strip_xpose_pkg;

    localparam int AMP_W  = 8;
    localparam int WORD_W = AMP_W + 1;

    typedef struct packed {
        logic             hit;
        logic [AMP_W-1:0] amp;
    } smp_word_t;

    function automatic logic word_has_hit(input logic [WORD_W-1:0] w);
        smp_word_t t;
        t = smp_word_t'(w);
        return t.hit;
    endfunction

endpackage

// File: rtl/sxb_bank.sv
module sxb_bank #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 9,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/sxb_write_ctrl.sv
module sxb_write_ctrl #(
    parameter int NUM_CHIPS = 4,
    parameter int CHANNELS  = 128,
    parameter int SAMPLES   = 6,
    localparam int CH_W  = $clog2(CHANNELS),
    localparam int SMP_W = $clog2(SAMPLES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            busy,
    input  logic [NUM_CHIPS-1:0]            in_valid,
    input  logic [NUM_CHIPS-1:0][CH_W-1:0]  in_chan,
    input  logic [NUM_CHIPS-1:0][SMP_W-1:0] in_smp,
    output logic [NUM_CHIPS-1:0]            accept,
    output logic                            evt_done
);

    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLES - 1);

    logic [NUM_CHIPS-1:0] chip_done;
    logic [NUM_CHIPS-1:0] last_word;

    always_comb begin
        accept = in_valid & {NUM_CHIPS{~busy}};
        for (int c = 0; c < NUM_CHIPS; c++) begin
            last_word[c] = accept[c] && (in_chan[c] == CH_LAST) && (in_smp[c] == SMP_LAST);
        end
        evt_done = (&(chip_done | last_word)) && (|last_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_done <= '0;
        end else if (evt_done) begin
            chip_done <= '0;
        end else begin
            chip_done <= chip_done | last_word;
        end
    end

    // R4: completing an event always leaves the per-chip tracking cleared
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
        evt_done |=> (chip_done == '0));

endmodule

// File: rtl/sxb_pingpong.sv
module sxb_pingpong (
    input  logic clk,
    input  logic rst,
    input  logic evt_done,
    input  logic rd_release,
    output logic wr_buf,
    output logic rd_buf,
    output logic wr_busy,
    output logic rd_ready
);

    logic [1:0] full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= '0;
            wr_buf <= 1'b0;
            rd_buf <= 1'b0;
        end else begin
            if (evt_done) begin
                full[wr_buf] <= 1'b1;
                wr_buf       <= ~wr_buf;
            end
            if (rd_release) begin
                full[rd_buf] <= 1'b0;
                rd_buf       <= ~rd_buf;
            end
        end
    end

    assign wr_busy  = full[wr_buf];
    assign rd_ready = full[rd_buf];

    // R8: the read side only frees a buffer that holds a completed event
    assert_release_held_R8: assert property (@(posedge clk) disable iff (rst)
        rd_release |-> full[rd_buf]);

endmodule

// File: rtl/sxb_read_seq.sv
module sxb_read_seq
    import strip_xpose_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int CHANNELS  = 128,
    parameter int SAMPLES   = 6,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int CHIP_W  = $clog2(NUM_CHIPS),
    localparam int STRIP_W = CH_W + CHIP_W
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          cfg_skip,
    input  logic                                          rd_ready,
    input  logic [NUM_CHIPS-1:0][SAMPLES-1:0][WORD_W-1:0] bank_q,
    output logic                                          rd_en,
    output logic [CH_W-1:0]                               rd_ch,
    output logic                                          rd_release,
    output logic                                          rd_active,
    output logic                                          out_valid,
    output logic [STRIP_W-1:0]                            out_strip,
    output logic [SAMPLES-1:0][WORD_W-1:0]                out_samples,
    output logic                                          out_last
);

    localparam logic [STRIP_W-1:0] STRIP_LAST = STRIP_W'(NUM_CHIPS * CHANNELS - 1);

    logic [STRIP_W-1:0] strip_cnt;
    logic               s1_valid;
    logic [STRIP_W-1:0] s1_strip;
    logic [CHIP_W-1:0]  sel_chip;
    logic [SAMPLES-1:0][WORD_W-1:0] sel_words;
    logic               sel_hit;
    logic               keep;

    assign rd_en      = rd_active;
    assign rd_ch      = strip_cnt[CH_W-1:0];
    assign rd_release = rd_active && (strip_cnt == STRIP_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            strip_cnt <= '0;
        end else if (rd_active) begin
            strip_cnt <= strip_cnt + 1'b1;
            if (strip_cnt == STRIP_LAST) begin
                rd_active <= 1'b0;
            end
        end else if (rd_ready) begin
            rd_active <= 1'b1;
            strip_cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_strip <= '0;
        end else begin
            s1_valid <= rd_active;
            s1_strip <= strip_cnt;
        end
    end

    always_comb begin
        sel_chip  = s1_strip[STRIP_W-1 -: CHIP_W];
        sel_words = bank_q[sel_chip];
        sel_hit   = 1'b0;
        for (int s = 0; s < SAMPLES; s++) begin
            sel_hit = sel_hit | word_has_hit(sel_words[s]);
        end
        keep = s1_valid && (!cfg_skip || sel_hit || (s1_strip == STRIP_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_strip <= '0;
        end else begin
            out_valid <= keep;
            out_last  <= keep && (s1_strip == STRIP_LAST);
            if (keep) begin
                out_strip   <= s1_strip;
                out_samples <= sel_words;
            end
        end
    end

    function automatic logic rec_hit(input logic [SAMPLES-1:0][WORD_W-1:0] r);
        logic h;
        h = 1'b0;
        for (int s = 0; s < SAMPLES; s++) h = h | word_has_hit(r[s]);
        return h;
    endfunction

    assert_last_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_last_strip_R7: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_strip == STRIP_LAST));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(out_last)) |-> (out_strip > $past(out_strip)));

    assert_skip_filter_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_skip) && !out_last) |-> rec_hit(out_samples));

endmodule

// File: rtl/strip_xpose_buf.sv
module strip_xpose_buf
    import strip_xpose_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int CHANNELS  = 128,
    parameter int SAMPLES   = 6,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int SMP_W   = $clog2(SAMPLES),
    localparam int CHIP_W  = $clog2(NUM_CHIPS),
    localparam int STRIP_W = CH_W + CHIP_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_skip_empty,
    input  logic [NUM_CHIPS-1:0]              in_valid,
    input  logic [NUM_CHIPS-1:0][CH_W-1:0]    in_chan,
    input  logic [NUM_CHIPS-1:0][SMP_W-1:0]   in_smp,
    input  logic [NUM_CHIPS-1:0][WORD_W-1:0]  in_data,
    output logic                              in_busy,
    output logic                              out_valid,
    output logic [STRIP_W-1:0]                out_strip,
    output logic [SAMPLES-1:0][WORD_W-1:0]    out_samples,
    output logic                              out_last
);

    localparam int BANK_DEPTH = 2 * CHANNELS;

    logic [NUM_CHIPS-1:0] accept;
    logic                 evt_done;
    logic                 wr_buf, rd_buf, rd_ready;
    logic                 rd_en, rd_release, rd_active;
    logic [CH_W-1:0]      rd_ch;
    logic [NUM_CHIPS-1:0][SAMPLES-1:0][WORD_W-1:0] bank_q;

    sxb_write_ctrl #(
        .NUM_CHIPS(NUM_CHIPS), .CHANNELS(CHANNELS), .SAMPLES(SAMPLES)
    ) u_wr (
        .clk(clk), .rst(rst), .busy(in_busy),
        .in_valid(in_valid), .in_chan(in_chan), .in_smp(in_smp),
        .accept(accept), .evt_done(evt_done)
    );

    sxb_pingpong u_pp (
        .clk(clk), .rst(rst), .evt_done(evt_done), .rd_release(rd_release),
        .wr_buf(wr_buf), .rd_buf(rd_buf), .wr_busy(in_busy), .rd_ready(rd_ready)
    );

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        for (genvar s = 0; s < SAMPLES; s++) begin : g_smp
            sxb_bank #(.DEPTH(BANK_DEPTH), .DATA_W(WORD_W)) u_bank (
                .clk(clk),
                .we(accept[c] && (in_smp[c] == SMP_W'(s))),
                .waddr({wr_buf, in_chan[c]}),
                .wdata(in_data[c]),
                .re(rd_en),
                .raddr({rd_buf, rd_ch}),
                .rdata(bank_q[c][s])
            );
        end
    end

    sxb_read_seq #(
        .NUM_CHIPS(NUM_CHIPS), .CHANNELS(CHANNELS), .SAMPLES(SAMPLES)
    ) u_rd (
        .clk(clk), .rst(rst), .cfg_skip(cfg_skip_empty), .rd_ready(rd_ready),
        .bank_q(bank_q), .rd_en(rd_en), .rd_ch(rd_ch), .rd_release(rd_release),
        .rd_active(rd_active), .out_valid(out_valid), .out_strip(out_strip),
        .out_samples(out_samples), .out_last(out_last)
    );

    // R9: both buffers can only be occupied while the older one is being read
    assert_busy_reading_R9: assert property (@(posedge clk) disable iff (rst)
        in_busy |-> rd_active);

    // R9: the write side never completes an event while it is blocked
    assert_no_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
        in_busy |-> !evt_done);

endmodule

// File: tb/strip_xpose_buf_tb.sv
module strip_xpose_buf_tb;

    localparam int NCH    = 4;
    localparam int CH     = 16;
    localparam int SMP    = 3;
    localparam int CHW    = 4;
    localparam int SMW    = 2;
    localparam int STW    = 6;
    localparam int STRIPS = NCH * CH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_skip_empty = 1'b0;
    logic [NCH-1:0]          in_valid = '0;
    logic [NCH-1:0][CHW-1:0] in_chan  = '0;
    logic [NCH-1:0][SMW-1:0] in_smp   = '0;
    logic [NCH-1:0][8:0]     in_data  = '0;
    logic                    in_busy;
    logic                    out_valid;
    logic [STW-1:0]          out_strip;
    logic [SMP-1:0][8:0]     out_samples;
    logic                    out_last;

    always #5 clk = ~clk;

    strip_xpose_buf #(.NUM_CHIPS(NCH), .CHANNELS(CH), .SAMPLES(SMP)) u_dut (
        .clk(clk), .rst(rst), .cfg_skip_empty(cfg_skip_empty),
        .in_valid(in_valid), .in_chan(in_chan), .in_smp(in_smp), .in_data(in_data),
        .in_busy(in_busy), .out_valid(out_valid), .out_strip(out_strip),
        .out_samples(out_samples), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    int ev_id   [0:15];
    bit ev_skip [0:15];
    int ev_head = 0;
    int ev_tail = 0;
    int mon_ptr = -1;

    function automatic logic [8:0] word_of(int e, int c, int ch, int s);
        logic       h;
        logic [7:0] a;
        h = (((ch + s + e + c) % 7) == 0);
        a = 8'((e * 29 + c * 61 + ch * 13 + s * 5 + 3) & 255);
        return {h, a};
    endfunction

    function automatic bit strip_hit(int e, int st);
        bit h = 0;
        for (int s = 0; s < SMP; s++) h = h | word_of(e, st / CH, st % CH, s)[8];
        return h;
    endfunction

    function automatic int next_strip(int e, bit sk, int from);
        for (int st = from; st < STRIPS; st++) begin
            if (!sk || strip_hit(e, st) || st == STRIPS - 1) return st;
        end
        return STRIPS - 1;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Record monitor: R2 mapping, R3 order/layout, R5 full sweep, R6 skip, R7 last
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ev_head == ev_tail) begin
                checks++; fails++;
                $display("FAIL R4 R9 unexpected record actual=strip %0d expected=none", out_strip);
            end else begin
                int  e;
                bit  sk;
                bit  ok;
                e  = ev_id[ev_head];
                sk = ev_skip[ev_head];
                if (mon_ptr < 0) mon_ptr = next_strip(e, sk, 0);
                ok = (int'(out_strip) == mon_ptr) && (out_last == (mon_ptr == STRIPS - 1));
                for (int s = 0; s < SMP; s++) begin
                    if (out_samples[s] != word_of(e, mon_ptr / CH, mon_ptr % CH, s)) ok = 0;
                end
                checks++;
                if (!ok) begin
                    fails++;
                    $display("FAIL R2 R3 R5 R6 R7 event %0d actual=strip %0d last %0b data %h expected=strip %0d data %h",
                             e, out_strip, out_last, out_samples, mon_ptr,
                             {word_of(e, mon_ptr / CH, mon_ptr % CH, 2),
                              word_of(e, mon_ptr / CH, mon_ptr % CH, 1),
                              word_of(e, mon_ptr / CH, mon_ptr % CH, 0)});
                end
                if (out_last) begin
                    ev_head++;
                    mon_ptr = -1;
                end else begin
                    mon_ptr = next_strip(e, sk, mon_ptr + 1);
                end
            end
        end
    end

    task automatic write_event(int e, bit sk);
        for (int s = 0; s < SMP; s++) begin
            for (int ch = 0; ch < CH; ch++) begin
                @(negedge clk);
                for (int c = 0; c < NCH; c++) begin
                    in_valid[c] = 1'b1;
                    in_chan[c]  = CHW'(ch);
                    in_smp[c]   = SMW'(s);
                    in_data[c]  = word_of(e, c, ch, s);
                end
            end
        end
        @(negedge clk);
        in_valid = '0;
        ev_id[ev_tail]   = e;
        ev_skip[ev_tail] = sk;
        ev_tail++;
    endtask

    task automatic wait_idle();
        while (ev_head != ev_tail) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    bit timed_out = 0;

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                // R1: reset state
                check(out_valid == 0, "R1 out_valid", out_valid, 0);
                check(out_last == 0,  "R1 out_last", out_last, 0);
                check(in_busy == 0,   "R1 in_busy", in_busy, 0);

                // R4 R5 R8: back-to-back events, no filtering
                write_event(0, 0);
                write_event(1, 0);
                wait_idle();
                check(ev_head == 2, "R8 events read", ev_head, 2);

                // R6: filtering enabled
                cfg_skip_empty = 1'b1;
                write_event(2, 1);
                write_event(3, 1);
                wait_idle();
                check(ev_head == 4, "R6 events read", ev_head, 4);
                cfg_skip_empty = 1'b0;

                // R9 R10: fill both buffers, offer dropped writes
                write_event(4, 0);
                write_event(5, 0);
                check(in_busy == 1, "R9 busy both full", in_busy, 1);
                for (int k = 0; k < 4; k++) begin
                    for (int c = 0; c < NCH; c++) begin
                        in_valid[c] = 1'b1;
                        in_chan[c]  = CHW'(CH - 1 - k);
                        in_smp[c]   = SMW'(SMP - 1);
                        in_data[c]  = 9'h1EE;
                    end
                    @(negedge clk);
                end
                in_valid = '0;
                check(in_busy == 1, "R9 busy held", in_busy, 1);
                begin
                    int n = 0;
                    while (in_busy && n < 2 * STRIPS) begin
                        @(negedge clk);
                        n++;
                    end
                    check(n <= STRIPS + 4, "R10 busy release cycles", n, STRIPS + 4);
                end
                write_event(6, 0);
                wait_idle();
                check(ev_head == 7, "R8 R9 event count", ev_head, 7);
                repeat (STRIPS * 2) @(negedge clk);
                check(out_valid == 0, "R9 no stray output", out_valid, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule